// File: doc/BRIEF.md
# Clockless Level-Capture Interrupt Bank

This block is a bank of eight interrupt channels for signals that may arrive while the bus clock is gated off, such as power-down indications. Each channel has a level-sensitive sticky latch. It sets the moment its input reaches the selected active level while the channel is enabled, and no clock edge is involved. The latch keeps the event until software clears it, even after the input has returned to its idle level.

Software programs a per-channel enable and a per-channel polarity through a small register port. A polarity bit of 0 means active-high and 1 means active-low. Latched status reaches the bus through a two-flop synchronizer. Software reads raw status, and masked status which is raw status AND enable. A single interrupt output is the OR of the masked status. Only level sensing is provided. Software that wants edge behaviour flips the polarity after each event. A write of 1 to a bit of the clear register drops that channel's latch for one cycle. If the input is still active at that point, the latch sets again at once.

The register port is a plain single-cycle write strobe with a combinational read. It carries no stream data, so it has no valid/ready handshake and no back-pressure.

Top module: `lvl_capture_bank`

## Requirements
- R1: After reset the enable, polarity, raw status and masked status registers read 0 and `irq_o` is 0.
- R2: With polarity bit 0 (active-high), a channel whose enable bit is 1 latches when its input is 1. The status bit at offset 0x04 (bit n for channel n) stays 1 after the input returns to 0.
- R3: With polarity bit 1 at offset 0x10, the channel latches on input 0 and ignores input 1.
- R4: A channel whose enable bit (offset 0x00) is 0 never latches, whatever its input does. The enable register reads back what was written.
- R5: Capture needs no clock. A pulse that starts and ends while the clock is stopped is reported once the clock runs again.
- R6: Writing a byte to offset 0x0C clears exactly the channels whose bits are 1 and leaves the others latched. Offset 0x0C reads 0.
- R7: A clear written while the channel's input is still active leaves its status at 1.
- R8: Masked status at offset 0x08 equals raw status AND enable, and `irq_o` is 1 exactly when masked status is nonzero. Disabling a latched channel hides it from masked status and `irq_o` but keeps its raw bit.
- R9: A new capture appears in raw status after the second rising clock edge that follows it, and is not yet visible after the first.
- R10: The mode register at offset 0x14 always reads 0xFF (all channels level mode), and writes to it have no effect. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, may be stopped |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data, one bit per channel |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| evt_in | input | 8 | Raw event inputs, one per channel |
| irq_o | output | 1 | OR of masked status |

## Verification
The bench drives single-channel pulses under both polarities to show that the active level is chosen per channel and that the latch outlives the pulse. A pulse applied while the clock is frozen separates true clockless capture from any sampled scheme. A partial clear over two latched channels, and a clear against a held input, tell bitwise clearing apart from a global clear and show that an active level takes priority. A pulse on a disabled channel, and disabling a channel that already latched, show the difference between the enable that gates capture and the mask applied to `irq_o`. Sampling one edge and then two edges after a capture pins the synchronizer latency.

// File: rtl/lvl_capture_pkg.sv
package lvl_capture_pkg;
  localparam int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 5'h00;
  localparam logic [REG_AW-1:0] OFS_RAW    = 5'h04;
  localparam logic [REG_AW-1:0] OFS_MASKED = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_POL    = 5'h10;
  localparam logic [REG_AW-1:0] OFS_MODE   = 5'h14;
endpackage

// File: rtl/lvl_capture_cell.sv
// One sticky level latch. Set has priority over clear, so a clear
// issued while the input is active leaves the cell set.
module lvl_capture_cell (
  input  logic rst_n,
  input  logic arm,
  input  logic pin,
  input  logic low_active,
  input  logic clr,
  output logic held
);
  logic hit;
  assign hit = arm & (pin ^ low_active);

  always_latch begin
    if (!rst_n)   held = 1'b0;
    else if (hit) held = 1'b1;
    else if (clr) held = 1'b0;
  end
endmodule

// File: rtl/lvl_capture_sync.sv
module lvl_capture_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lvl_capture_bank.sv
module lvl_capture_bank
  import lvl_capture_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [NCH-1:0]    reg_wdata,
  output logic [NCH-1:0]    reg_rdata,
  input  logic [NCH-1:0]    evt_in,
  output logic              irq_o
);
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] pol_q;
  logic [NCH-1:0] clr_q;
  logic [NCH-1:0] lat_q;
  logic [NCH-1:0] stat_sync;
  logic [NCH-1:0] masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      clr_q <= '0;
    end else begin
      clr_q <= (reg_we && reg_addr == OFS_CLEAR) ? reg_wdata : '0;
      if (reg_we && reg_addr == OFS_ENABLE) en_q  <= reg_wdata;
      if (reg_we && reg_addr == OFS_POL)    pol_q <= reg_wdata;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cell
    lvl_capture_cell u_cell (
      .rst_n      (rst_n),
      .arm        (en_q[g]),
      .pin        (evt_in[g]),
      .low_active (pol_q[g]),
      .clr        (clr_q[g]),
      .held       (lat_q[g])
    );
  end

  lvl_capture_sync #(.W(NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (lat_q),
    .q     (stat_sync)
  );

  assign masked = stat_sync & en_q;
  assign irq_o  = |masked;

  always_comb begin
    case (reg_addr)
      OFS_ENABLE: reg_rdata = en_q;
      OFS_RAW:    reg_rdata = stat_sync;
      OFS_MASKED: reg_rdata = masked;
      OFS_POL:    reg_rdata = pol_q;
      OFS_MODE:   reg_rdata = '1;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lvl_capture_chk.sv
module lvl_capture_chk
  import lvl_capture_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic [NCH-1:0]    reg_rdata,
  input logic [NCH-1:0]    lat_q,
  input logic [NCH-1:0]    stat_sync,
  input logic [NCH-1:0]    en_q,
  input logic              irq_o
);
  assert_sync_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sync == $past(lat_q, 2));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0 && stat_sync != '0));

  assert_mode_all_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_MODE) |-> reg_rdata == '1);

  assert_clear_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_CLEAR) |-> reg_rdata == '0);
endmodule

bind lvl_capture_bank lvl_capture_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .lat_q     (lat_q),
  .stat_sync (stat_sync),
  .en_q      (en_q),
  .irq_o     (irq_o)
);

// File: tb/tb_lvl_capture_bank.sv
module tb_lvl_capture_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] evt_in = '0;
  logic       irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lvl_capture_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_o(irq_o)
  );

  initial forever begin
    #(CLK_PERIOD/2);
    if (clk_run) clk = ~clk;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic quiet();
    wr(5'h00, 8'h00);
    wr(5'h10, 8'h00);
    evt_in = '0;
    wr(5'h0C, 8'hFF);
    tick(3);
  endtask

  task automatic t_reset();
    rd(5'h00, "R1 enable", 8'h00);
    rd(5'h10, "R1 polarity", 8'h00);
    rd(5'h04, "R1 raw", 8'h00);
    rd(5'h08, "R1 masked", 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_high_hold();
    wr(5'h00, 8'h01);
    evt_in[0] = 1'b1;
    tick(1);
    rd(5'h04, "R9 one edge", 8'h00);
    tick(1);
    rd(5'h04, "R9 two edges", 8'h01);
    evt_in[0] = 1'b0;
    tick(3);
    rd(5'h04, "R2 held after release", 8'h01);
    rd(5'h08, "R8 masked", 8'h01);
    chk("R8 irq set", {7'd0, irq_o}, 8'h01);
    wr(5'h0C, 8'h01);
    tick(3);
    rd(5'h04, "R6 cleared", 8'h00);
    chk("R8 irq clear", {7'd0, irq_o}, 8'h00);
    quiet();
  endtask

  task automatic t_low_active();
    evt_in[2] = 1'b1;
    wr(5'h10, 8'h04);
    rd(5'h10, "R3 polarity readback", 8'h04);
    wr(5'h00, 8'h04);
    tick(3);
    rd(5'h04, "R3 high ignored", 8'h00);
    evt_in[2] = 1'b0;
    tick(3);
    rd(5'h04, "R3 low captured", 8'h04);
    evt_in[2] = 1'b1;
    wr(5'h0C, 8'h04);
    tick(3);
    rd(5'h04, "R3 cleared", 8'h00);
    quiet();
  endtask

  task automatic t_disabled();
    wr(5'h00, 8'hDF);
    rd(5'h00, "R4 enable readback", 8'hDF);
    wr(5'h00, 8'h00);
    evt_in[5] = 1'b1;
    tick(2);
    evt_in[5] = 1'b0;
    tick(3);
    rd(5'h04, "R4 disabled no capture", 8'h00);
    quiet();
  endtask

  task automatic t_clockless();
    wr(5'h00, 8'h08);
    clk_run = 1'b0;
    #(CLK_PERIOD*3);
    evt_in[3] = 1'b1;
    #(CLK_PERIOD);
    evt_in[3] = 1'b0;
    #(CLK_PERIOD*2);
    clk_run = 1'b1;
    tick(3);
    rd(5'h04, "R5 capture while stopped", 8'h08);
    quiet();
  endtask

  task automatic t_partial_clear();
    wr(5'h00, 8'h0A);
    evt_in = 8'h0A;
    tick(1);
    evt_in = 8'h00;
    tick(3);
    rd(5'h04, "R6 two latched", 8'h0A);
    wr(5'h0C, 8'h02);
    tick(3);
    rd(5'h04, "R6 only bit1 cleared", 8'h08);
    rd(5'h0C, "R6 clear reads zero", 8'h00);
    quiet();
  endtask

  task automatic t_clear_active();
    evt_in[4] = 1'b1;
    wr(5'h00, 8'h10);
    tick(3);
    wr(5'h0C, 8'h10);
    tick(3);
    rd(5'h04, "R7 clear while active", 8'h10);
    evt_in[4] = 1'b0;
    wr(5'h0C, 8'h10);
    tick(3);
    rd(5'h04, "R7 clear after release", 8'h00);
    quiet();
  endtask

  task automatic t_mask();
    wr(5'h00, 8'h40);
    evt_in[6] = 1'b1;
    tick(1);
    evt_in[6] = 1'b0;
    tick(3);
    wr(5'h00, 8'h00);
    tick(1);
    rd(5'h04, "R8 raw kept", 8'h40);
    rd(5'h08, "R8 masked hidden", 8'h00);
    chk("R8 irq hidden", {7'd0, irq_o}, 8'h00);
    quiet();
  endtask

  task automatic t_mode();
    rd(5'h14, "R10 mode", 8'hFF);
    wr(5'h14, 8'h00);
    rd(5'h14, "R10 mode after write", 8'hFF);
    rd(5'h18, "R10 unmapped", 8'h00);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_high_hold();
    t_low_active();
    t_disabled();
    t_clockless();
    t_partial_clear();
    t_clear_active();
    t_mask();
    t_mode();
    done = 1'b1;
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
  end

  initial begin
    wait (done || $time >= CLK_PERIOD*20000);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule